// File: doc/BRIEF.md
# Configurable Host Bus Front-End

This block sits at the pins of a parallel slave port and turns whatever external processor bus is attached into a clean internal access stream. A handful of run-time configuration inputs choose the active level of the data and address strobes, pick between one combined data strobe with a direction line and a pair of separate read and write strobes, and select whether the register index comes from dedicated address pins or is captured from the low bits of a shared address/data bus. Every external strobe crosses into the internal clock domain through a two-stage synchroniser. The block then emits a single-cycle read or write pulse together with a 3-bit register index.

On the return side it drives the host request pads. Two internal request levels (transmit and receive) are mapped onto one combined pad or onto two separate pads. Each pad is driven either push-pull or as an open-drain output, modelled as a pad value plus an output enable. The register file and data buffers behind the port are not part of this block.

Top module: `hbf_front_end`

## Requirements
- R1: While reset is applied, and until the first access, `rd_pulse`, `wr_pulse`, `rd_oe` and `strobe_err` are 0, and with requests disabled both bits of `req_pad_oe` are 0.
- R2: With `cfg_ds_pol`=0 a data strobe is asserted when its pin is low. With `cfg_ds_pol`=1 it is asserted when the pin is high. The setting applies to `hb_ds`, `hb_rd` and `hb_wr` alike.
- R3: With `cfg_as_pol`=0 the address strobe `hb_as` is asserted when low, and with `cfg_as_pol`=1 when high. In multiplexed mode the internal address latch follows `hb_ad` on every clock while the strobe is asserted, and keeps its value after the strobe is released.
- R4: With `cfg_mux`=1, `reg_sel` is taken from the address latch (bits 2:0 of `hb_ad`). With `cfg_mux`=0 it is taken from `hb_addr` and `hb_ad` has no effect on it.
- R5: With `cfg_dual`=0, `hb_ds` qualifies every access and `hb_rw` gives the direction: 1 means read, 0 means write. `hb_rd` and `hb_wr` are ignored.
- R6: With `cfg_dual`=1, `hb_rd` alone produces reads and `hb_wr` alone produces writes. `hb_ds` and `hb_rw` are ignored, and `rd_pulse` and `wr_pulse` are never high together.
- R7: A strobe that becomes asserted just after a falling clock edge yields exactly one pulse. The pulse is high for the single clock cycle that follows the second rising edge, and no further pulse appears while the strobe stays asserted.
- R8: `rd_oe` is 1 while a qualified read is in progress (from the pulse cycle until the released strobe has passed the synchroniser) and is 0 during writes and when idle.
- R9: In dual-strobe mode, while the read and write strobes are both asserted, `strobe_err` is 1. A strobe whose assertion edge falls while the other strobe is asserted produces no pulse.
- R10: Unless `cfg_req_en` and `cfg_if_en` are both 1, both bits of `req_pad_oe` are 0 (pads high-impedance).
- R11: Requests enabled with `cfg_od`=0 (push-pull): every used pad has its enable at 1 and drives low while its request is active and high otherwise.
- R12: Requests enabled with `cfg_od`=1 (open-drain): the pad value is always 0 and a pad's enable is 1 only while its request is active.
- R13: With `cfg_dbl_req`=0, pad 0 carries `req_tx` OR `req_rx` and pad 1 is never enabled. With `cfg_dbl_req`=1, pad 0 carries `req_tx` and pad 1 carries `req_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ds_pol | input | 1 | Data strobe active level (0 low, 1 high) |
| cfg_as_pol | input | 1 | Address strobe active level (0 low, 1 high) |
| cfg_mux | input | 1 | 1: index from latched shared bus, 0: from address pins |
| cfg_dual | input | 1 | 1: separate read/write strobes, 0: combined strobe plus direction |
| cfg_od | input | 1 | 1: open-drain request pads, 0: push-pull |
| cfg_req_en | input | 1 | Request output enable |
| cfg_if_en | input | 1 | Interface enable |
| cfg_dbl_req | input | 1 | 1: separate transmit/receive request pads |
| hb_ds | input | 1 | Combined data strobe pin |
| hb_rw | input | 1 | Direction pin (1 read, 0 write) |
| hb_rd | input | 1 | Read strobe pin |
| hb_wr | input | 1 | Write strobe pin |
| hb_as | input | 1 | Address strobe pin |
| hb_ad | input | AD_W (8) | Shared address/data bus |
| hb_addr | input | SEL_W (3) | Dedicated address pins |
| req_tx | input | 1 | Internal transmit request level |
| req_rx | input | 1 | Internal receive request level |
| rd_pulse | output | 1 | Single-cycle internal read |
| wr_pulse | output | 1 | Single-cycle internal write |
| reg_sel | output | SEL_W (3) | Register index presented with each pulse |
| rd_oe | output | 1 | Read data output enable |
| strobe_err | output | 1 | Read and write strobes asserted together |
| req_pad_o | output | 2 | Request pad values (low means request) |
| req_pad_oe | output | 2 | Request pad output enables |

## Verification
The bench targets the multiplexed case where the data phase puts a different value on the shared bus after the address strobe closes. A latch that kept following the bus would report the data bits as the index. In direct mode it drives the opposite value on the bus to catch a wrong source select. It runs the same transfers under both strobe levels: an inverted polarity shows up as a pulse on release instead of assertion, or as an extra pulse. It also overlaps the read and write strobes, where a careless design issues a phantom pulse or misses the error flag. It walks every request drive combination, catching a pad that drives high in open-drain mode or stays enabled when requests are off.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  localparam int unsigned REQ_PADS = 2;

  typedef struct packed {
    logic ds;
    logic rw;
    logic rd;
    logic wr;
    logic adr;
  } hbf_strb_t;

  localparam int unsigned STRB_W = $bits(hbf_strb_t);
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg_d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbf_strobe_decode.sv
module hbf_strobe_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic dual,
  input  logic ds_a,
  input  logic rw,
  input  logic rd_a,
  input  logic wr_a,
  output logic rd_pulse,
  output logic wr_pulse,
  output logic rd_oe,
  output logic strobe_err
);
  logic [2:0] prev_q, prev_d;
  logic       ds_rise, rd_rise, wr_rise;

  always_comb begin
    prev_d = {ds_a, rd_a, wr_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    ds_rise = ds_a & ~prev_q[2];
    rd_rise = rd_a & ~prev_q[1];
    wr_rise = wr_a & ~prev_q[0];
    if (dual) begin
      rd_pulse   = rd_rise & ~wr_a;
      wr_pulse   = wr_rise & ~rd_a;
      rd_oe      = rd_a & ~wr_a;
      strobe_err = rd_a & wr_a;
    end else begin
      rd_pulse   = ds_rise & rw;
      wr_pulse   = ds_rise & ~rw;
      rd_oe      = ds_a & rw;
      strobe_err = 1'b0;
    end
  end
endmodule

// File: rtl/hbf_addr_path.sv
module hbf_addr_path #(
  parameter int unsigned AD_W  = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mux,
  input  logic             as_a,
  input  logic [AD_W-1:0]  ad_s,
  input  logic [SEL_W-1:0] addr_s,
  output logic [SEL_W-1:0] sel
);
  logic [SEL_W-1:0] lat_q, lat_d;
  logic             lat_en;

  always_comb begin
    lat_en = mux & as_a;
    lat_d  = ad_s[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  always_comb begin
    sel = mux ? lat_q : addr_s;
  end
endmodule

// File: rtl/hbf_req_drive.sv
module hbf_req_drive
  import hbf_pkg::*;
(
  input  logic                req_en,
  input  logic                if_en,
  input  logic                od,
  input  logic                dbl,
  input  logic                req_tx,
  input  logic                req_rx,
  output logic [REQ_PADS-1:0] pad_o,
  output logic [REQ_PADS-1:0] pad_oe
);
  logic [REQ_PADS-1:0] lvl, used;
  logic                on;

  always_comb begin
    on      = req_en & if_en;
    lvl[0]  = dbl ? req_tx : (req_tx | req_rx);
    lvl[1]  = req_rx;
    used[0] = 1'b1;
    used[1] = dbl;
    for (int i = 0; i < int'(REQ_PADS); i++) begin
      if (!on || !used[i]) begin
        pad_o[i]  = 1'b0;
        pad_oe[i] = 1'b0;
      end else if (od) begin
        pad_o[i]  = 1'b0;
        pad_oe[i] = lvl[i];
      end else begin
        pad_o[i]  = ~lvl[i];
        pad_oe[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hbf_front_end.sv
module hbf_front_end
  import hbf_pkg::*;
#(
  parameter int unsigned AD_W        = 8,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_ds_pol,
  input  logic                cfg_as_pol,
  input  logic                cfg_mux,
  input  logic                cfg_dual,
  input  logic                cfg_od,
  input  logic                cfg_req_en,
  input  logic                cfg_if_en,
  input  logic                cfg_dbl_req,
  input  logic                hb_ds,
  input  logic                hb_rw,
  input  logic                hb_rd,
  input  logic                hb_wr,
  input  logic                hb_as,
  input  logic [AD_W-1:0]     hb_ad,
  input  logic [SEL_W-1:0]    hb_addr,
  input  logic                req_tx,
  input  logic                req_rx,
  output logic                rd_pulse,
  output logic                wr_pulse,
  output logic [SEL_W-1:0]    reg_sel,
  output logic                rd_oe,
  output logic                strobe_err,
  output logic [REQ_PADS-1:0] req_pad_o,
  output logic [REQ_PADS-1:0] req_pad_oe
);
  localparam int unsigned SYNC_W = STRB_W + AD_W + SEL_W;

  logic [1:0]        rst_pipe;
  logic              rst_i_n;
  hbf_strb_t         strb_raw, strb_s;
  logic [SYNC_W-1:0] sync_d, sync_q;
  logic [AD_W-1:0]   ad_s;
  logic [SEL_W-1:0]  addr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  always_comb begin
    strb_raw.ds  = cfg_ds_pol ? hb_ds : ~hb_ds;
    strb_raw.rd  = cfg_ds_pol ? hb_rd : ~hb_rd;
    strb_raw.wr  = cfg_ds_pol ? hb_wr : ~hb_wr;
    strb_raw.adr = cfg_as_pol ? hb_as : ~hb_as;
    strb_raw.rw  = hb_rw;
    sync_d       = {strb_raw, hb_ad, hb_addr};
  end

  hbf_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     (sync_d),
    .q     (sync_q)
  );

  assign {strb_s, ad_s, addr_s} = sync_q;

  hbf_strobe_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .dual       (cfg_dual),
    .ds_a       (strb_s.ds),
    .rw         (strb_s.rw),
    .rd_a       (strb_s.rd),
    .wr_a       (strb_s.wr),
    .rd_pulse   (rd_pulse),
    .wr_pulse   (wr_pulse),
    .rd_oe      (rd_oe),
    .strobe_err (strobe_err)
  );

  hbf_addr_path #(.AD_W(AD_W), .SEL_W(SEL_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .mux    (cfg_mux),
    .as_a   (strb_s.adr),
    .ad_s   (ad_s),
    .addr_s (addr_s),
    .sel    (reg_sel)
  );

  hbf_req_drive u_req (
    .req_en (cfg_req_en),
    .if_en  (cfg_if_en),
    .od     (cfg_od),
    .dbl    (cfg_dbl_req),
    .req_tx (req_tx),
    .req_rx (req_rx),
    .pad_o  (req_pad_o),
    .pad_oe (req_pad_oe)
  );
endmodule

// File: rtl/hbf_front_end_chk.sv
module hbf_front_end_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_dual,
  input logic       cfg_od,
  input logic       cfg_req_en,
  input logic       cfg_if_en,
  input logic       cfg_dbl_req,
  input logic       req_tx,
  input logic       req_rx,
  input logic       rd_pulse,
  input logic       wr_pulse,
  input logic       rd_oe,
  input logic       strobe_err,
  input logic [1:0] req_pad_o,
  input logic [1:0] req_pad_oe
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> !rd_pulse); // R7
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R7
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pulse && wr_pulse)); // R6
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |-> rd_oe); // R8
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |-> !(rd_pulse || wr_pulse)); // R9
  AST_ERR_DUAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |-> cfg_dual); // R9
  AST_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req_en && cfg_if_en) |-> (req_pad_oe == 2'b00)); // R10
  AST_PP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_en && cfg_if_en && !cfg_od && cfg_dbl_req) |-> (req_pad_oe == 2'b11)); // R11
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_en && cfg_if_en && cfg_od) |-> (req_pad_o == 2'b00)); // R12
  AST_OD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_en && cfg_if_en && cfg_od && cfg_dbl_req) |-> (req_pad_oe == {req_rx, req_tx})); // R12
  AST_SINGLE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dbl_req |-> !req_pad_oe[1]); // R13
endmodule

bind hbf_front_end hbf_front_end_chk u_chk (.*);

// File: tb/hbf_front_end_bench.sv
module hbf_front_end_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_ds_pol, cfg_as_pol, cfg_mux, cfg_dual, cfg_od;
  logic       cfg_req_en, cfg_if_en, cfg_dbl_req;
  logic       hb_ds, hb_rw, hb_rd, hb_wr, hb_as;
  logic [7:0] hb_ad;
  logic [2:0] hb_addr;
  logic       req_tx, req_rx;
  logic       rd_pulse, wr_pulse, rd_oe, strobe_err;
  logic [2:0] reg_sel;
  logic [1:0] req_pad_o, req_pad_oe;

  int checks = 0;
  int errors = 0;
  bit live   = 1'b0;
  bit done   = 1'b0;
  logic [3:0] expq[$];

  always #4 clk = ~clk;

  hbf_front_end u_hbf_front_end (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every pulse pops one expected {is_rd, sel}
  always @(negedge clk) begin
    if (live && (rd_pulse || wr_pulse)) begin
      if (expq.size() == 0) chk(1'b0, "R7 unexpected pulse", {rd_pulse, reg_sel}, 0);
      else begin
        logic [3:0] e;
        e = expq.pop_front();
        chk({rd_pulse, reg_sel} == e && (rd_pulse != wr_pulse), "R4/R5/R6 pulse kind+sel",
            {rd_pulse, reg_sel}, e);
      end
    end
  end

  task automatic idle_pins();
    hb_ds = ~cfg_ds_pol; hb_rd = ~cfg_ds_pol; hb_wr = ~cfg_ds_pol; hb_as = ~cfg_as_pol;
  endtask

  task automatic set_cfg(input bit dsp, input bit asp, input bit mx, input bit du);
    @(negedge clk); #1;
    cfg_ds_pol = dsp; cfg_as_pol = asp; cfg_mux = mx; cfg_dual = du;
    idle_pins();
    repeat (5) @(negedge clk);
  endtask

  // driver: one access, pushes its expectation, checks R7 timing and R8
  task automatic access(input bit is_rd, input logic [2:0] sel);
    @(negedge clk); #1;
    if (cfg_mux) begin
      hb_addr = ~sel;
      hb_ad   = {5'b10110, sel};
      hb_as   = cfg_as_pol;
      repeat (4) @(negedge clk);
      #1 hb_as = ~cfg_as_pol;
      repeat (3) @(negedge clk);
      #1 hb_ad = {5'b01001, ~sel};           // data phase value, R3 hold
      repeat (3) @(negedge clk);
      #1;
    end else begin
      hb_addr = sel;
      hb_ad   = {5'b11111, ~sel};            // R4 must be ignored
    end
    hb_rw = is_rd;
    expq.push_back({is_rd, sel});
    if (cfg_dual) begin
      if (is_rd) hb_rd = cfg_ds_pol; else hb_wr = cfg_ds_pol;
    end else begin
      hb_ds = cfg_ds_pol;
    end
    @(negedge clk);
    chk(!(rd_pulse || wr_pulse), "R7 no pulse after 1st edge", {rd_pulse, wr_pulse}, 0);
    @(negedge clk);
    chk(is_rd ? rd_pulse : wr_pulse, "R7 pulse after 2nd edge", {rd_pulse, wr_pulse},
        is_rd ? 2 : 1);
    chk(rd_oe == is_rd, "R8 rd_oe during access", rd_oe, is_rd);
    @(negedge clk);
    chk(!(rd_pulse || wr_pulse), "R7 single-cycle pulse", {rd_pulse, wr_pulse}, 0);
    repeat (3) @(negedge clk);
    chk(!(rd_pulse || wr_pulse), "R7 no repeat while held", {rd_pulse, wr_pulse}, 0);
    #1 idle_pins();
    repeat (4) @(negedge clk);
    chk(rd_oe == 1'b0, "R8 rd_oe idle after access", rd_oe, 0);
  endtask

  task automatic req_case(input bit en, input bit ie, input bit od, input bit dbl,
                          input bit tx, input bit rx);
    logic [1:0] eo, eoe;
    logic l0;
    cfg_req_en = en; cfg_if_en = ie; cfg_od = od; cfg_dbl_req = dbl;
    req_tx = tx; req_rx = rx;
    #1;
    l0 = dbl ? tx : (tx | rx);
    if (!(en && ie)) begin eo = 2'b00; eoe = 2'b00; end
    else if (od) begin eo = 2'b00; eoe = {dbl & rx, l0}; end
    else begin eo = {dbl & ~rx, ~l0}; eoe = {dbl, 1'b1}; end
    chk(req_pad_oe == eoe, (!(en && ie)) ? "R10 pad enable" : (od ? "R12 pad enable" :
        "R11 pad enable"), req_pad_oe, eoe);
    chk((req_pad_o & eoe) == eo, dbl ? "R13 pad value double" : "R13 pad value single",
        req_pad_o & eoe, eo);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_ds_pol = 0; cfg_as_pol = 0; cfg_mux = 0; cfg_dual = 0; cfg_od = 0;
    cfg_req_en = 0; cfg_if_en = 0; cfg_dbl_req = 0;
    hb_rw = 0; hb_ad = '0; hb_addr = '0; req_tx = 1; req_rx = 1;
    idle_pins();
    repeat (4) @(negedge clk);
    chk({rd_pulse, wr_pulse, rd_oe, strobe_err} == 4'b0, "R1 outputs in reset",
        {rd_pulse, wr_pulse, rd_oe, strobe_err}, 0);
    chk(req_pad_oe == 2'b00, "R1 pads off in reset", req_pad_oe, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({rd_pulse, wr_pulse, rd_oe, strobe_err} == 4'b0, "R1 idle after reset",
        {rd_pulse, wr_pulse, rd_oe, strobe_err}, 0);
    live = 1'b1;

    // R5 single strobe, active low, direct address
    access(1'b1, 3'd5);
    access(1'b0, 3'd2);
    // R2 active-high data strobe
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
    access(1'b1, 3'd7);
    access(1'b0, 3'd0);
    // R5: stray hb_rd/hb_wr activity is ignored in single mode
    @(negedge clk); #1 hb_rd = cfg_ds_pol; hb_wr = cfg_ds_pol;
    repeat (6) @(negedge clk);
    chk(!(rd_pulse || wr_pulse || strobe_err), "R5 rd/wr pins ignored", {rd_pulse, wr_pulse}, 0);
    #1 idle_pins();
    repeat (4) @(negedge clk);
    // R3/R4 multiplexed address, both address strobe levels
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
    access(1'b1, 3'd3);
    access(1'b0, 3'd6);
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0);
    access(1'b0, 3'd1);
    access(1'b1, 3'd4);
    // R6 dual strobe, both polarities
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1);
    access(1'b1, 3'd2);
    access(1'b0, 3'd5);
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1);
    access(1'b0, 3'd7);
    access(1'b1, 3'd1);
    // R6 hb_ds ignored in dual mode
    @(negedge clk); #1 hb_ds = cfg_ds_pol;
    repeat (6) @(negedge clk);
    chk(!(rd_pulse || wr_pulse), "R6 hb_ds ignored in dual", {rd_pulse, wr_pulse}, 0);
    #1 idle_pins();
    repeat (4) @(negedge clk);
    // R9 simultaneous strobes
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk); #1 hb_addr = 3'd3; hb_rd = 1'b0; hb_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(strobe_err == 1'b1, "R9 error on overlap", strobe_err, 1);
    chk(rd_oe == 1'b0, "R9 no read drive on overlap", rd_oe, 0);
    #1 idle_pins();
    repeat (4) @(negedge clk);
    chk(strobe_err == 1'b0, "R9 error clears", strobe_err, 0);
    // write held, then read added: write pulses, read does not
    @(negedge clk); #1 expq.push_back({1'b0, 3'd3}); hb_wr = 1'b0;
    repeat (5) @(negedge clk);
    #1 hb_rd = 1'b0;
    repeat (4) @(negedge clk);
    chk(strobe_err == 1'b1, "R9 error on late read", strobe_err, 1);
    #1 idle_pins();
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R7 all expected pulses seen", expq.size(), 0);

    // request drive R10..R13
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      req_case(k[5], k[4], k[3], k[2], k[1], k[0]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule